// File: doc/BRIEF.md
# Accumulator Fetch-Execute Processor Core

This block is a small single-accumulator processor. It fetches 16-bit instruction words from a unified word-addressed memory, decodes a 4-bit operation code, and carries out each instruction as a fixed sequence of register transfers. These transfers pass through a program counter, a memory address register, a memory data register, an instruction register and the accumulator. Every state of the sequence moves one value from one register to another. This keeps the timing of each instruction fixed and easy to predict.

Instruction words keep the operation code in bits 15:12 and a 12-bit operand in bits 11:0. For memory instructions the operand is an address. For device instructions it is a device number. Memory sits outside the core behind a synchronous port with one cycle of read latency. Device traffic uses a numbered device select, an input word qualified by a valid flag, and an output word qualified by a one-cycle strobe. After reset, execution begins at the address on the start input. Execution continues until a halt, after which the core stays halted until the next reset.

Top module: `acc_core`

## Requirements
- R1: Every instruction begins with a six-cycle fetch. The fetch presents the program counter on `mem_addr`, takes the read word one cycle later, moves it into the instruction register, increments the program counter, and then decodes. No memory write, strobe or halt occurs during a fetch.
- R2: LOAD (1), ADD (2) and SUB (4) take four cycles after the fetch. Their results are the memory word at the operand address, the accumulator plus that word, and the accumulator minus that word, with 16-bit wrap-around.
- R3: STORE (3) takes three cycles after the fetch. In the third of them, `mem_we` is high for exactly one cycle, with `mem_addr` equal to the operand and `mem_wdata` equal to the accumulator.
- R4: The condition code holds exactly one of zero, positive and negative for the accumulator, read as a two's-complement value. It is refreshed only by LOAD, ADD, SUB and IN. Reset sets it to zero.
- R5: SKIPZ (9), SKIPG (A) and SKIPL (B) each take one cycle. Each advances the program counter past the next instruction when its flag is set, and otherwise has no effect.
- R6: JMP (8) takes one cycle and loads the program counter with the operand.
- R7: IN (5) drives the operand on `dev_sel` and waits with no time limit until `in_valid` is high. It then loads `in_data` into the accumulator in that same cycle.
- R8: OUT (6) drives the operand on `dev_sel` and raises `out_stb` for one cycle, with `out_data` equal to the accumulator.
- R9: HALT (7), and the undefined codes 0 and C through F, raise `halted` in the cycle after decode. From then until reset, `halted` stays high and no write or strobe occurs, whatever the inputs do.
- R10: During reset, `halted`, `mem_we` and `out_stb` are low. Execution then begins by fetching from `start_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_addr | input | 12 | Address of the first instruction after reset |
| mem_addr | output | 12 | Memory address, from the address register |
| mem_wdata | output | 16 | Memory write word, from the data register |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read word, one cycle after the address |
| dev_sel | output | 12 | Device number of the current IN or OUT |
| in_data | input | 16 | Device input word |
| in_valid | input | 1 | Device input word is present |
| out_data | output | 16 | Device output word (the accumulator) |
| out_stb | output | 1 | Device output word is present for one cycle |
| halted | output | 1 | Core has stopped |

## Verification
The assertions assume that `in_valid` is sampled only while an IN waits, so a stray pulse outside that state must leave the accumulator alone. They also assume that memory returns the addressed word exactly one cycle after the address is presented. The bench memory model is a simple synchronous RAM that provides exactly that latency. The bench raises `in_valid` only inside the IN wait window, after a chosen number of idle cycles. It also toggles it freely once the core has halted, where the halt assertions require it to have no effect.

// File: rtl/acc_pkg.sv
// Shared definitions for the accumulator core: operation codes, sequencer
// states, ALU selects and the bit positions of the condition code.
// Assumes a 4-bit operation code in the top bits of each instruction word.
package acc_pkg;
    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'h2;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'h3;
    localparam logic [OPC_W-1:0] OPC_SUB   = 4'h4;
    localparam logic [OPC_W-1:0] OPC_IN    = 4'h5;
    localparam logic [OPC_W-1:0] OPC_OUT   = 4'h6;
    localparam logic [OPC_W-1:0] OPC_HALT  = 4'h7;
    localparam logic [OPC_W-1:0] OPC_JMP   = 4'h8;
    localparam logic [OPC_W-1:0] OPC_SKZ   = 4'h9;
    localparam logic [OPC_W-1:0] OPC_SKG   = 4'hA;
    localparam logic [OPC_W-1:0] OPC_SKL   = 4'hB;

    // Condition code bit positions.
    localparam int CC_NEG  = 0;
    localparam int CC_ZERO = 1;
    localparam int CC_POS  = 2;
    localparam int CC_W    = 3;

    typedef enum logic [4:0] {
        SQ_F_MAR, SQ_F_RD, SQ_F_MDR, SQ_F_IR, SQ_F_PC, SQ_DEC,
        SQ_X_MAR, SQ_X_RD, SQ_X_MDR, SQ_X_ACC,
        SQ_S_MDR, SQ_S_WR,
        SQ_JMP, SQ_SKIP, SQ_IN, SQ_OUT, SQ_HALT
    } seq_e;

    typedef enum logic [1:0] {
        ALU_PASS, ALU_ADD, ALU_SUB
    } alu_sel_e;
endpackage

// File: rtl/acc_alu.sv
// Accumulator arithmetic: pass-through, add or subtract of two words.
// Assumes modular (wrap-around) arithmetic at the data width.
module acc_alu
    import acc_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_sel_e       sel,
    input  logic [W-1:0]   acc,
    input  logic [W-1:0]   opnd,
    output logic [W-1:0]   res
);
    // Select the result for the current operation.
    always_comb begin
        unique case (sel)
            ALU_ADD: res = acc + opnd;
            ALU_SUB: res = acc - opnd;
            default: res = opnd;
        endcase
    end
endmodule

// File: rtl/acc_flags.sv
// Condition code generator: classifies a two's-complement word as
// negative, zero or positive. Exactly one output bit is set.
module acc_flags
    import acc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]    val,
    output logic [CC_W-1:0] cc
);
    // Sign and zero tests; positive is neither.
    always_comb begin
        cc          = '0;
        cc[CC_NEG]  = val[W-1];
        cc[CC_ZERO] = (val == '0);
        cc[CC_POS]  = !val[W-1] && (val != '0);
    end
endmodule

// File: rtl/acc_core.sv
// Accumulator fetch-execute core. Each sequencer state performs one register
// transfer among PC, MAR, MDR, IR and the accumulator. Assumes memory returns
// the word addressed by mem_addr one clock after it is presented.
module acc_core
    import acc_pkg::*;
#(
    parameter  int ADDR_W = 12,
    localparam int DATA_W = OPC_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] dev_sel,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_stb,
    output logic              halted
);
    seq_e              state_q, state_d;
    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [DATA_W-1:0] mdr_q, ir_q, acc_q;
    logic [CC_W-1:0]   cc_q, cc_new;
    logic [OPC_W-1:0]  opc;
    logic [ADDR_W-1:0] opnd_addr;
    alu_sel_e          alu_sel;
    logic [DATA_W-1:0] alu_b, alu_res;
    logic              skip_take;
    logic              in_wait;

    assign opc       = ir_q[DATA_W-1 -: OPC_W];
    assign opnd_addr = ir_q[ADDR_W-1:0];
    assign in_wait   = (state_q == SQ_IN);

    // Choose the ALU function from the decoded operation.
    always_comb begin
        unique case (opc)
            OPC_ADD: alu_sel = ALU_ADD;
            OPC_SUB: alu_sel = ALU_SUB;
            default: alu_sel = ALU_PASS;
        endcase
    end

    assign alu_b = in_wait ? in_data : mdr_q;

    acc_alu #(.W(DATA_W)) u_alu (
        .sel  (alu_sel),
        .acc  (acc_q),
        .opnd (alu_b),
        .res  (alu_res)
    );

    acc_flags #(.W(DATA_W)) u_flg (
        .val (alu_res),
        .cc  (cc_new)
    );

    // Decide whether the current skip instruction jumps over the next word.
    always_comb begin
        unique case (opc)
            OPC_SKZ: skip_take = cc_q[CC_ZERO];
            OPC_SKG: skip_take = cc_q[CC_POS];
            OPC_SKL: skip_take = cc_q[CC_NEG];
            default: skip_take = 1'b0;
        endcase
    end

    // Sequencer next-state: fixed micro-sequences per operation.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_F_MAR: state_d = SQ_F_RD;
            SQ_F_RD:  state_d = SQ_F_MDR;
            SQ_F_MDR: state_d = SQ_F_IR;
            SQ_F_IR:  state_d = SQ_F_PC;
            SQ_F_PC:  state_d = SQ_DEC;
            SQ_DEC: begin
                unique case (opc)
                    OPC_LOAD, OPC_ADD, OPC_SUB, OPC_STORE: state_d = SQ_X_MAR;
                    OPC_IN:                   state_d = SQ_IN;
                    OPC_OUT:                  state_d = SQ_OUT;
                    OPC_JMP:                  state_d = SQ_JMP;
                    OPC_SKZ, OPC_SKG, OPC_SKL: state_d = SQ_SKIP;
                    default:                  state_d = SQ_HALT;
                endcase
            end
            SQ_X_MAR: state_d = (opc == OPC_STORE) ? SQ_S_MDR : SQ_X_RD;
            SQ_X_RD:  state_d = SQ_X_MDR;
            SQ_X_MDR: state_d = SQ_X_ACC;
            SQ_X_ACC: state_d = SQ_F_MAR;
            SQ_S_MDR: state_d = SQ_S_WR;
            SQ_S_WR:  state_d = SQ_F_MAR;
            SQ_JMP, SQ_SKIP, SQ_OUT: state_d = SQ_F_MAR;
            SQ_IN:    state_d = in_valid ? SQ_F_MAR : SQ_IN;
            SQ_HALT:  state_d = SQ_HALT;
            default:  state_d = SQ_F_MAR;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_F_MAR;
        else        state_q <= state_d;
    end

    // Register transfers performed in each sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= start_addr;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
            acc_q <= '0;
            cc_q  <= CC_W'(1 << CC_ZERO);
        end else begin
            unique case (state_q)
                SQ_F_MAR: mar_q <= pc_q;
                SQ_F_MDR: mdr_q <= mem_rdata;
                SQ_F_IR:  ir_q  <= mdr_q;
                SQ_F_PC:  pc_q  <= pc_q + 1'b1;
                SQ_X_MAR: mar_q <= opnd_addr;
                SQ_X_MDR: mdr_q <= mem_rdata;
                SQ_X_ACC: begin
                    acc_q <= alu_res;
                    cc_q  <= cc_new;
                end
                SQ_S_MDR: mdr_q <= acc_q;
                SQ_JMP:   pc_q  <= opnd_addr;
                SQ_SKIP:  if (skip_take) pc_q <= pc_q + 1'b1;
                SQ_IN: begin
                    if (in_valid) begin
                        acc_q <= alu_res;
                        cc_q  <= cc_new;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign mem_we    = (state_q == SQ_S_WR);
    assign dev_sel   = opnd_addr;
    assign out_data  = acc_q;
    assign out_stb   = (state_q == SQ_OUT);
    assign halted    = (state_q == SQ_HALT);
endmodule

// File: rtl/acc_core_chk.sv
// Property checker for the accumulator core, bound to every acc_core
// instance. Assumes the inputs follow the port contract in the brief.
module acc_core_chk #(
    parameter int DW = 16,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          halted,
    input logic          mem_we,
    input logic [DW-1:0] mem_wdata,
    input logic          out_stb,
    input logic [CW-1:0] cc,
    input logic [DW-1:0] acc,
    input logic          in_wait,
    input logic          in_valid
);
    assert_cc_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc) == 1);

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_we && !out_stb));

    assert_store_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == acc));

    assert_store_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_out_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |=> !out_stb);

    assert_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !in_valid) |=> ($stable(acc) && in_wait));
endmodule

bind acc_core acc_core_chk #(.DW(DATA_W), .CW(acc_pkg::CC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halted    (halted),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .out_stb   (out_stb),
    .cc        (cc_q),
    .acc       (acc_q),
    .in_wait   (in_wait),
    .in_valid  (in_valid)
);

// File: tb/acc_core_test.sv
// Bench for acc_core: a behavioural instruction interpreter predicts every
// cycle's port activity and compares it at each falling clock edge.
module acc_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] start_addr;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] dev_sel;
    logic [DW-1:0] in_data;
    logic          in_valid;
    logic [DW-1:0] out_data;
    logic          out_stb;
    logic          halted;

    logic          ld_en;
    logic [AW-1:0] ld_a;
    logic [DW-1:0] ld_d;
    logic [DW-1:0] ram [1 << AW];
    logic [DW-1:0] rm  [1 << AW];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int in_vals[$];
    int in_waits[$];

    acc_core #(.ADDR_W(AW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_addr (start_addr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_rdata  (mem_rdata),
        .dev_sel    (dev_sel),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .out_data   (out_data),
        .out_stb    (out_stb),
        .halted     (halted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Synchronous RAM with one-cycle read latency and a preload path.
    always @(posedge clk) begin
        if (ld_en)       ram[ld_a] <= ld_d;
        else if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle of expected port activity, sampled mid-cycle.
    task automatic step(input logic e_we, input logic e_stb, input logic e_halt,
                        input logic [AW-1:0] e_adr, input logic [DW-1:0] e_dat,
                        input bit dchk, input logic [AW-1:0] e_dev, input string req);
        check(mem_we === e_we, req, "mem_we", 32'(mem_we), 32'(e_we));
        check(out_stb === e_stb, req, "out_stb", 32'(out_stb), 32'(e_stb));
        check(halted === e_halt, req, "halted", 32'(halted), 32'(e_halt));
        if (e_we) begin
            check(mem_addr === e_adr, req, "mem_addr", 32'(mem_addr), 32'(e_adr));
            check(mem_wdata === e_dat, req, "mem_wdata", 32'(mem_wdata), 32'(e_dat));
        end
        if (e_stb)
            check(out_data === e_dat, req, "out_data", 32'(out_data), 32'(e_dat));
        if (dchk)
            check(dev_sel === e_dev, req, "dev_sel", 32'(dev_sel), 32'(e_dev));
        @(negedge clk);
    endtask

    task automatic idle(input string req);
        step(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0, req);
    endtask

    task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
        ld_en = 1'b1; ld_a = a; ld_d = d; rm[a] = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Enter reset, check the idle outputs (R10).
    task automatic enter_reset(input logic [AW-1:0] s);
        rst_n = 1'b0; start_addr = s; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(halted === 1'b0, "R10", "halted in reset", 32'(halted), 0);
        check(mem_we === 1'b0, "R10", "mem_we in reset", 32'(mem_we), 0);
        check(out_stb === 1'b0, "R10", "out_stb in reset", 32'(out_stb), 0);
    endtask

    // Reference interpreter: releases reset and follows the program to halt.
    task automatic run(input logic [AW-1:0] s);
        logic [AW-1:0] pc;
        logic [DW-1:0] acc, ir, v;
        logic [AW-1:0] a;
        logic [3:0]    op;
        bit z, g, l, done;
        pc = s; acc = '0; z = 1; g = 0; l = 0; done = 0;
        rst_n = 1'b1;
        for (int n = 0; n < 200 && !done; n++) begin
            repeat (6) idle("R1");
            ir = rm[pc]; pc = pc + 1'b1;
            op = ir[15:12]; a = ir[11:0];
            case (op)
                4'h1, 4'h2, 4'h4: begin
                    repeat (4) idle("R2");
                    v = rm[a];
                    if (op == 4'h1)      acc = v;
                    else if (op == 4'h2) acc = acc + v;
                    else                 acc = acc - v;
                    z = (acc == 0); l = acc[15]; g = !z && !l;
                end
                4'h3: begin
                    repeat (2) idle("R3");
                    step(1'b1, 1'b0, 1'b0, a, acc, 1'b0, '0, "R3");
                    rm[a] = acc;
                end
                4'h5: begin
                    int w = in_waits.pop_front();
                    v = DW'(in_vals.pop_front());
                    for (int k = 0; k < w; k++)
                        step(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, a, "R7");
                    in_valid = 1'b1; in_data = v;
                    step(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, a, "R7");
                    in_valid = 1'b0;
                    acc = v;
                    z = (acc == 0); l = acc[15]; g = !z && !l;
                end
                4'h6: step(1'b0, 1'b1, 1'b0, '0, acc, 1'b1, a, "R8");
                4'h8: begin idle("R6"); pc = a; end
                4'h9, 4'hA, 4'hB: begin
                    idle("R5");
                    if ((op == 4'h9 && z) || (op == 4'hA && g) || (op == 4'hB && l))
                        pc = pc + 1'b1;
                end
                default: begin
                    for (int k = 0; k < 5; k++) begin
                        in_valid = k[0]; in_data = 16'h1234;
                        step(1'b0, 1'b0, 1'b1, '0, '0, 1'b0, '0, "R9");
                    end
                    in_valid = 1'b0;
                    done = 1;
                end
            endcase
        end
        check(done, "R9", "program reached halt", 32'(done), 1);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; ld_en = 1'b0;
        ld_a = '0; ld_d = '0; start_addr = '0;

        // T1: add two words and store the sum (R2, R3, R10).
        enter_reset(12'h003);
        poke(12'h000, 16'd1245); poke(12'h001, 16'd1755); poke(12'h002, 16'd0);
        poke(12'h003, 16'h1000); poke(12'h004, 16'h2001);
        poke(12'h005, 16'h3002); poke(12'h006, 16'h7000);
        run(12'h003);
        check(ram[2] === 16'd3000, "R3", "stored sum", 32'(ram[2]), 3000);

        // T2: device input, subtract, all skips, jump, output, overflow (R2, R4-R8).
        enter_reset(12'h010);
        poke(12'h100, 16'd10); poke(12'h101, 16'd3); poke(12'h102, 16'hFFFF);
        poke(12'h103, 16'h7FFF); poke(12'h104, 16'h0000); poke(12'h105, 16'h0001);
        poke(12'h010, 16'h5005);  // IN dev 5
        poke(12'h011, 16'hA000);  // SKIPG -> taken
        poke(12'h012, 16'h7000);
        poke(12'h013, 16'h4100);  // SUB -> -3
        poke(12'h014, 16'h9000);  // SKIPZ -> not taken
        poke(12'h015, 16'h6009);  // OUT dev 9
        poke(12'h016, 16'hB000);  // SKIPL -> taken
        poke(12'h017, 16'h7000);
        poke(12'h018, 16'h2101);  // ADD -> 0
        poke(12'h019, 16'h9000);  // SKIPZ -> taken
        poke(12'h01A, 16'h7000);
        poke(12'h01B, 16'h3102);  // STORE 0
        poke(12'h01C, 16'h8020);  // JMP
        poke(12'h01D, 16'h7000);
        poke(12'h020, 16'h1103);  // LOAD 7FFF
        poke(12'h021, 16'h2105);  // ADD 1 -> 8000
        poke(12'h022, 16'hA000);  // SKIPG -> not taken
        poke(12'h023, 16'h3104);  // STORE
        poke(12'h024, 16'h6007);  // OUT dev 7
        poke(12'h025, 16'hC000);  // undefined -> halt
        in_vals.push_back(7); in_waits.push_back(3);
        run(12'h010);
        check(ram[12'h102] === 16'h0000, "R5", "zero stored after skips", 32'(ram[12'h102]), 0);
        check(ram[12'h104] === 16'h8000, "R2", "wrapped sum stored", 32'(ram[12'h104]), 32'h8000);

        // T3: reset flag is zero, skip taken, opcode 0 halts (R4, R5, R9, R10).
        enter_reset(12'h300);
        poke(12'h300, 16'h9000); poke(12'h301, 16'h7000); poke(12'h302, 16'h0000);
        run(12'h300);

        // T4: IN without wait, flags from input, SKIPL on negative input (R7, R4).
        enter_reset(12'h400);
        poke(12'h400, 16'h5009); poke(12'h401, 16'hB000); poke(12'h402, 16'h7000);
        poke(12'h403, 16'h6005); poke(12'h404, 16'hF000);
        in_vals.push_back(16'hFF00); in_waits.push_back(0);
        run(12'h400);

        summary();
        $finish;
    end
endmodule